// File: doc/BRIEF.md
# SDRAM Write-Burst Ending Sequencer

This block is the command-issue stage of an SDRAM controller. It decides how a write burst ends. It takes one request per cycle: a write, a read or a precharge. A write carries a bank, a column, a burst-length code and an auto-precharge flag. A precharge may name a single bank or all banks. An accepted request drives the SDRAM command, bank and address lines in the same cycle. The data-drive enable and the byte mask are driven alongside.

A write burst can end in four ways. It can run its full length. A later write can replace it. A read can cut it short, and no data is driven from the read cycle onward. A precharge to the bank can also cut it short. When a precharge cuts a burst short, the block masks the unwanted beats. It holds the precharge back until write recovery has passed since the last wanted beat. Each bank has its own timers for write recovery and row precharge, and for an auto-precharge that is still pending. A request that would break one of these timing rules is held off: ready stays low and a no-operation command is driven.

Write recovery is derived from the clock period parameter. Row-precharge time is given in clocks. Row activation, refresh, initialization, mode-register setup and read data return are handled elsewhere.

Top module: `wbs_seq`

## Requirements
- R1: An accepted write drives command {ras_n,cas_n,we_n}=100 in the same cycle. The column goes on the low address bits and address bit 10 carries the effective auto-precharge flag. The data enable is high and the mask is low in that cycle.
- R2: Burst-length codes 0 to 3 give 1, 2, 4 or 8 beats, with the data enable high on consecutive cycles starting at the write cycle. A code with bit 2 set is a full-page burst that continues until it is ended by a command.
- R3: An accepted read drives command 101 with the column on the low address bits and address bit 10 low. The data enable is low in the read cycle, and the interrupted burst drives no further beats.
- R4: A precharge issues no earlier than write recovery after the last wanted beat to its bank. Write recovery is 1 clock when CLK_PS is 15000 or more and 2 clocks otherwise.
- R5: A precharge request that hits the bank of a running burst without auto-precharge stops the burst's data from that cycle on. From that cycle through the precharge cycle, the mask is high and the data enable is low.
- R6: After a precharge (command 010, address bit 10 high for all banks), no command reaches an affected bank until TRP_CYC cycles later.
- R7: A fixed burst with auto-precharge that runs to completion blocks its bank exactly as long as an explicit precharge issued at the earliest legal time would.
- R8: Any request to the bank of a running auto-precharge burst is held until that burst has completed and its precharge time has passed.
- R9: Writes are accepted on back-to-back cycles to any bank. Each new write ends the previous burst.
- R10: While a valid request has ready low, and out of reset, the command is 111 (no operation).
- R11: A full-page write ignores the auto-precharge flag: address bit 10 is driven low and the bank is not auto-precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 write, 1 read, 2 precharge, 3 none |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Start column |
| req_blen | input | 3 | Burst-length code |
| req_auto | input | 1 | Auto-precharge for a write |
| req_all | input | 1 | Precharge all banks |
| sd_cmd | output | 3 | {ras_n,cas_n,we_n} |
| sd_bank | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Address lines |
| dq_oe | output | 1 | Drive write data this cycle |
| dqm | output | 1 | Mask input data this cycle |

## Verification
The hardest case to reach is a precharge that arrives in the middle of a full-page burst while write recovery is still running. Only in that case is the mask raised on both the edge before the precharge and the precharge edge itself. The stimulus starts a full-page write, lets it run a few beats, then holds a precharge request to that bank. The expected stall and release cycles are computed from the recovery count. A second pair of sequences compares an auto-precharge burst with the same burst followed by an explicit precharge at the earliest allowed cycle. Both must release the bank on the same cycle.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   typedef enum logic [1:0] {
      REQ_WRITE = 2'd0,
      REQ_READ  = 2'd1,
      REQ_PRE   = 2'd2,
      REQ_NONE  = 2'd3
   } req_kind_e;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'b111,
      CMD_READ  = 3'b101,
      CMD_WRITE = 3'b100,
      CMD_PRE   = 3'b010
   } sd_cmd_e;

   // recovery after the last registered write beat, in clocks
   function automatic int recov_clocks(input int clk_ps);
      return (clk_ps >= 15000) ? 1 : 2;
   endfunction

endpackage

// File: rtl/wbs_bank_timer.sv
module wbs_bank_timer #(
   parameter int TWR = 2,
   parameter int TRP = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beat_i,
   input  logic pre_i,
   input  logic ap_arm_i,
   input  logic ap_now_i,
   output logic wr_idle_o,
   output logic rp_idle_o,
   output logic ap_pend_o
);
   localparam int MAXC = (TWR > TRP) ? TWR : TRP;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] wr_cnt, rp_cnt;
   logic          ap_pend, wr_zero, ap_fire;

   assign wr_zero = (wr_cnt == '0);
   assign ap_fire = (ap_pend | ap_now_i) & wr_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_cnt  <= '0;
         rp_cnt  <= '0;
         ap_pend <= 1'b0;
      end else begin
         if (beat_i)        wr_cnt <= CW'(TWR - 1);
         else if (!wr_zero) wr_cnt <= wr_cnt - 1'b1;

         if (pre_i | ap_fire)    rp_cnt <= CW'(TRP - 1);
         else if (rp_cnt != '0)  rp_cnt <= rp_cnt - 1'b1;

         if (ap_fire)                  ap_pend <= 1'b0;
         else if (ap_arm_i | ap_now_i) ap_pend <= 1'b1;
      end
   end

   assign wr_idle_o = wr_zero;
   assign rp_idle_o = (rp_cnt == '0);
   assign ap_pend_o = ap_pend;
endmodule

// File: rtl/wbs_burst_track.sv
module wbs_burst_track #(
   parameter int BANK_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_wr_i,
   input  logic [BANK_W-1:0] wr_bank_i,
   input  logic [2:0]        wr_bcode_i,
   input  logic              wr_auto_i,
   input  logic              term_i,
   input  logic              stop_req_i,
   output logic              active_o,
   output logic [BANK_W-1:0] bank_o,
   output logic              auto_o,
   output logic              stopped_o,
   output logic              beat_o,
   output logic              ap_arm_cur_o,
   output logic              ap_arm_new_o,
   output logic              ap_now_o
);
   logic              active, full, auto_q, stopped;
   logic [BANK_W-1:0] bank_q;
   logic [3:0]        left_q, bl;
   logic              last_cyc;

   assign bl       = 4'd1 << wr_bcode_i[1:0];
   assign last_cyc = active & ~full & (left_q == 4'd1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         full    <= 1'b0;
         auto_q  <= 1'b0;
         stopped <= 1'b0;
         bank_q  <= '0;
         left_q  <= '0;
      end else if (issue_wr_i) begin
         full    <= wr_bcode_i[2];
         active  <= wr_bcode_i[2] | (bl != 4'd1);
         left_q  <= bl - 4'd1;
         bank_q  <= wr_bank_i;
         auto_q  <= wr_auto_i;
         stopped <= 1'b0;
      end else if (term_i || last_cyc) begin
         active  <= 1'b0;
         stopped <= 1'b0;
      end else if (active) begin
         if (!full)      left_q  <= left_q - 4'd1;
         if (stop_req_i) stopped <= 1'b1;
      end
   end

   assign active_o     = active;
   assign bank_o       = bank_q;
   assign auto_o       = auto_q;
   assign stopped_o    = stopped;
   assign beat_o       = active & ~stopped & ~stop_req_i & ~term_i;
   assign ap_arm_cur_o = last_cyc & ~term_i & auto_q;
   assign ap_arm_new_o = issue_wr_i & ~wr_bcode_i[2] & (bl == 4'd1) & wr_auto_i;
   assign ap_now_o     = active & term_i & auto_q;
endmodule

// File: rtl/wbs_seq.sv
module wbs_seq #(
   parameter int BANK_W  = 2,
   parameter int COL_W   = 9,
   parameter int ADDR_W  = 13,
   parameter int AP_BIT  = 10,
   parameter int CLK_PS  = 5000,
   parameter int TRP_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [COL_W-1:0]  req_col,
   input  logic [2:0]        req_blen,
   input  logic              req_auto,
   input  logic              req_all,
   output logic [2:0]        sd_cmd,
   output logic [BANK_W-1:0] sd_bank,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              dq_oe,
   output logic              dqm
);
   import wbs_pkg::*;

   localparam int NB      = 1 << BANK_W;
   localparam int TWR_CYC = recov_clocks(CLK_PS);

   if (COL_W > AP_BIT) begin : g_bad_col
      $error("COL_W must fit below AP_BIT");
   end
   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside ADDR_W");
   end
   if (TRP_CYC < 1) begin : g_bad_trp
      $error("TRP_CYC must be at least 1");
   end

   req_kind_e         kind;
   logic              is_wr, is_rd, is_pre;
   logic [NB-1:0]     wr_idle, rp_idle, ap_pend, blk;
   logic              b_active, b_auto, b_stopped, b_beat;
   logic [BANK_W-1:0] b_bank;
   logic              ap_arm_cur, ap_arm_new, ap_now;
   logic              pre_hits, stop_req, issue, issue_wr, term, auto_eff;
   logic              ok_rw, ok_one, ok_all;

   assign kind     = req_kind_e'(req_kind);
   assign is_wr    = (kind == REQ_WRITE);
   assign is_rd    = (kind == REQ_READ);
   assign is_pre   = (kind == REQ_PRE);
   assign auto_eff = req_auto & ~req_blen[2];

   assign pre_hits = is_pre & b_active & ~b_auto & (req_all | (req_bank == b_bank));
   assign stop_req = req_valid & pre_hits;
   assign issue    = req_valid & req_ready;
   assign issue_wr = issue & is_wr;
   assign term     = issue & (is_wr | is_rd | pre_hits);

   always_comb begin
      ok_rw  = ~blk[req_bank];
      ok_one = ok_rw & wr_idle[req_bank];
      ok_all = 1'b1;
      for (int b = 0; b < NB; b++) begin
         if (blk[b] || !wr_idle[b]) ok_all = 1'b0;
      end
      unique case (kind)
         REQ_WRITE, REQ_READ: req_ready = ok_rw;
         REQ_PRE:             req_ready = req_all ? ok_all : ok_one;
         default:             req_ready = 1'b1;
      endcase
   end

   wbs_burst_track #(.BANK_W(BANK_W)) u_track (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue_wr_i   (issue_wr),
      .wr_bank_i    (req_bank),
      .wr_bcode_i   (req_blen),
      .wr_auto_i    (auto_eff),
      .term_i       (term),
      .stop_req_i   (stop_req),
      .active_o     (b_active),
      .bank_o       (b_bank),
      .auto_o       (b_auto),
      .stopped_o    (b_stopped),
      .beat_o       (b_beat),
      .ap_arm_cur_o (ap_arm_cur),
      .ap_arm_new_o (ap_arm_new),
      .ap_now_o     (ap_now)
   );

   for (genvar gb = 0; gb < NB; gb++) begin : g_bank
      logic hit_cur, hit_req;
      assign hit_cur = (b_bank == BANK_W'(gb));
      assign hit_req = (req_bank == BANK_W'(gb));
      assign blk[gb] = ~rp_idle[gb] | ap_pend[gb] | (b_active & b_auto & hit_cur);

      wbs_bank_timer #(.TWR(TWR_CYC), .TRP(TRP_CYC)) u_tmr (
         .clk       (clk),
         .rst_n     (rst_n),
         .beat_i    ((issue_wr & hit_req) | (b_beat & hit_cur)),
         .pre_i     (issue & is_pre & (req_all | hit_req)),
         .ap_arm_i  ((ap_arm_cur & hit_cur) | (ap_arm_new & hit_req)),
         .ap_now_i  (ap_now & hit_cur),
         .wr_idle_o (wr_idle[gb]),
         .rp_idle_o (rp_idle[gb]),
         .ap_pend_o (ap_pend[gb])
      );
   end

   assign dq_oe = issue_wr | b_beat;
   assign dqm   = b_active & (b_stopped | stop_req) & ~(issue & (is_wr | is_rd));

   always_comb begin
      sd_cmd  = CMD_NOP;
      sd_bank = '0;
      sd_addr = '0;
      if (issue) begin
         unique case (kind)
            REQ_WRITE: begin
               sd_cmd               = CMD_WRITE;
               sd_bank              = req_bank;
               sd_addr[COL_W-1:0]   = req_col;
               sd_addr[AP_BIT]      = auto_eff;
            end
            REQ_READ: begin
               sd_cmd               = CMD_READ;
               sd_bank              = req_bank;
               sd_addr[COL_W-1:0]   = req_col;
            end
            REQ_PRE: begin
               sd_cmd               = CMD_PRE;
               sd_bank              = req_bank;
               sd_addr[AP_BIT]      = req_all;
            end
            default: sd_cmd = CMD_NOP;
         endcase
      end
   end
endmodule

// File: rtl/wbs_checker.sv
module wbs_checker #(
   parameter int BANK_W  = 2,
   parameter int TRP_CYC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [2:0]        sd_cmd,
   input logic [BANK_W-1:0] sd_bank,
   input logic              sd_ap,
   input logic              dq_oe,
   input logic              dqm
);
   p_stall_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |-> (sd_cmd == 3'b111));

   p_write_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == 3'b100) |-> (dq_oe && !dqm));

   p_read_halts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == 3'b101) |-> !dq_oe);

   p_read_no_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == 3'b101) |=> (!dq_oe || sd_cmd == 3'b100));

   p_mask_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dqm |-> !dq_oe);

   if (TRP_CYC >= 2) begin : g_rp
      p_rp_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (sd_cmd == 3'b010) |=>
            (sd_cmd == 3'b111 || (!$past(sd_ap) && sd_bank != $past(sd_bank))));
   end
endmodule

bind wbs_seq wbs_checker #(.BANK_W(BANK_W), .TRP_CYC(TRP_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .sd_cmd    (sd_cmd),
   .sd_bank   (sd_bank),
   .sd_ap     (sd_addr[AP_BIT]),
   .dq_oe     (dq_oe),
   .dqm       (dqm)
);

// File: tb/wbs_seq_tb.sv
module wbs_seq_tb;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [2:0] NOP = 3'b111, WR = 3'b100, RD = 3'b101, PR = 3'b010;
   localparam logic [1:0] KW = 2'd0, KR = 2'd1, KP = 2'd2, KN = 2'd3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_ready, req_auto, req_all;
   logic [1:0]  req_kind, req_bank, sd_bank;
   logic [8:0]  req_col;
   logic [2:0]  req_blen, sd_cmd;
   logic [12:0] sd_addr;
   logic        dq_oe, dqm;

   typedef struct {
      int          cyc;
      logic [2:0]  cmd;
      logic [1:0]  bank;
      logic [12:0] addr;
      logic        oe, msk, rdy;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   exp_t e;
   int   cyc = 0, n_run = 0, n_fail = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc++;

   wbs_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_bank(req_bank), .req_col(req_col),
      .req_blen(req_blen), .req_auto(req_auto), .req_all(req_all),
      .sd_cmd(sd_cmd), .sd_bank(sd_bank), .sd_addr(sd_addr),
      .dq_oe(dq_oe), .dqm(dqm)
   );

   // monitor: compare the expected item queued for this cycle
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
         e = sbq.pop_front();
         n_run++;
         if (e.cyc < cyc) begin
            n_fail++;
            $display("FAIL %s: item missed, actual cycle %0d expected %0d", e.tag, cyc, e.cyc);
         end else if (req_ready !== e.rdy || sd_cmd !== e.cmd || dq_oe !== e.oe || dqm !== e.msk ||
                      (e.cmd != NOP && (sd_bank !== e.bank || sd_addr !== e.addr))) begin
            n_fail++;
            $display("FAIL %s: actual rdy=%b cmd=%b bank=%0d addr=%h oe=%b dqm=%b expected rdy=%b cmd=%b bank=%0d addr=%h oe=%b dqm=%b",
                     e.tag, req_ready, sd_cmd, sd_bank, sd_addr, dq_oe, dqm,
                     e.rdy, e.cmd, e.bank, e.addr, e.oe, e.msk);
         end
      end
   end

   // driver: one cycle of stimulus, with its expected outputs pushed
   task automatic step(input bit v, input logic [1:0] k, input logic [1:0] b,
                       input logic [8:0] c, input logic [2:0] bl, input bit au,
                       input bit al, input bit chk, input logic [2:0] ecmd,
                       input logic [1:0] eb, input logic [12:0] ea, input bit eoe,
                       input bit emsk, input bit erdy, input string tag);
      exp_t x;
      @(posedge clk); #1;
      req_valid = v; req_kind = k; req_bank = b; req_col = c;
      req_blen = bl; req_auto = au; req_all = al;
      if (chk) begin
         x.cyc = cyc; x.cmd = ecmd; x.bank = eb; x.addr = ea;
         x.oe = eoe; x.msk = emsk; x.rdy = erdy; x.tag = tag;
         sbq.push_back(x);
      end
   endtask

   task automatic quiet(input bit eoe, input bit emsk, input string tag);
      step(0, KN, 0, 0, 0, 0, 0, 1, NOP, 0, 0, eoe, emsk, 1, tag);
   endtask

   task automatic gap(input int n);
      for (int i = 0; i < n; i++) step(0, KN, 0, 0, 0, 0, 0, 0, NOP, 0, 0, 0, 0, 1, "");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R10: watchdog, actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_kind = KN; req_bank = '0; req_col = '0;
      req_blen = '0; req_auto = 1'b0; req_all = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      quiet(0, 0, "R10 reset state");

      // four-beat fixed burst
      step(1, KW, 1, 9'd5, 3'd2, 0, 0, 1, WR, 1, 13'h005, 1, 0, 1, "R1 write command");
      quiet(1, 0, "R2 beat 2");
      quiet(1, 0, "R2 beat 3");
      quiet(1, 0, "R2 beat 4");
      quiet(0, 0, "R2 burst ends after 4");
      gap(4);

      // full-page burst truncated by precharge
      step(1, KW, 2, 9'h010, 3'd7, 1, 0, 1, WR, 2, 13'h010, 1, 0, 1, "R11 full page drops auto");
      quiet(1, 0, "R2 full page continues");
      quiet(1, 0, "R2 full page continues");
      step(1, KP, 2, 0, 0, 0, 0, 1, NOP, 0, 0, 0, 1, 0, "R4 recovery hold, R5 mask before precharge");
      step(1, KP, 2, 0, 0, 0, 0, 1, PR, 2, 13'h000, 0, 1, 1, "R5 mask on precharge edge");
      step(1, KW, 2, 9'd3, 3'd0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R6 precharge time hold");
      step(1, KW, 2, 9'd3, 3'd0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R6 precharge time hold");
      step(1, KW, 2, 9'd3, 3'd0, 0, 0, 1, WR, 2, 13'h003, 1, 0, 1, "R6 released after precharge time");
      quiet(0, 0, "R2 single beat");
      gap(5);

      // read truncates an eight-beat burst
      step(1, KW, 0, 9'd0, 3'd3, 0, 0, 1, WR, 0, 13'h000, 1, 0, 1, "R1 write bank 0");
      quiet(1, 0, "R2 beat 2");
      quiet(1, 0, "R2 beat 3");
      step(1, KR, 3, 9'd7, 0, 0, 0, 1, RD, 3, 13'h007, 0, 0, 1, "R3 read truncates");
      quiet(0, 0, "R3 no further beats");
      quiet(0, 0, "R3 no further beats");
      gap(3);

      // back-to-back writes
      step(1, KW, 0, 9'd1, 3'd1, 0, 0, 1, WR, 0, 13'h001, 1, 0, 1, "R9 first write");
      step(1, KW, 1, 9'd2, 3'd1, 0, 0, 1, WR, 1, 13'h002, 1, 0, 1, "R9 back-to-back write");
      quiet(1, 0, "R9 second burst beat");
      quiet(0, 0, "R9 second burst ends");
      gap(3);

      // auto-precharge burst: bank blocked until L+tWR+tRP
      step(1, KW, 3, 9'd4, 3'd1, 1, 0, 1, WR, 3, 13'h404, 1, 0, 1, "R7 auto write");
      step(1, KR, 3, 9'd0, 0, 0, 0, 1, NOP, 0, 0, 1, 0, 0, "R8 held during auto burst");
      for (int i = 0; i < 4; i++)
         step(1, KR, 3, 9'd0, 0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R7 auto precharge window");
      step(1, KR, 3, 9'd0, 0, 0, 0, 1, RD, 3, 13'h000, 0, 0, 1, "R7 auto release cycle");
      gap(3);

      // same burst with explicit earliest precharge
      step(1, KW, 3, 9'd4, 3'd1, 0, 0, 1, WR, 3, 13'h004, 1, 0, 1, "R7 explicit write");
      quiet(1, 0, "R2 last beat");
      step(1, KP, 3, 0, 0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R4 recovery after last beat");
      step(1, KP, 3, 0, 0, 0, 0, 1, PR, 3, 13'h000, 0, 0, 1, "R4 earliest precharge");
      step(1, KR, 3, 9'd0, 0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R6 hold after precharge");
      step(1, KR, 3, 9'd0, 0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R6 hold after precharge");
      step(1, KR, 3, 9'd0, 0, 0, 0, 1, RD, 3, 13'h000, 0, 0, 1, "R7 matches auto release");
      gap(3);

      // all-bank precharge
      step(1, KP, 0, 0, 0, 0, 1, 1, PR, 0, 13'h400, 0, 0, 1, "R6 all-bank precharge");
      step(1, KW, 1, 9'd9, 3'd0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R6 all banks held");
      step(1, KW, 1, 9'd9, 3'd0, 0, 0, 1, NOP, 0, 0, 0, 0, 0, "R6 all banks held");
      step(1, KW, 1, 9'd9, 3'd0, 0, 0, 1, WR, 1, 13'h009, 1, 0, 1, "R6 other bank released");
      gap(3);

      if (sbq.size() != 0) begin
         n_fail++;
         $display("FAIL R10: %0d items unchecked, expected 0", sbq.size());
      end
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule